// File: doc/BRIEF.md
# Cache-Block Operation Permission Checker

This block decides whether a cache-block zeroing or management request (clean, flush or invalidate) may go ahead at the current privilege level. It reads three layers of per-operation enable bits: a machine layer, a hypervisor layer and a supervisor layer. It combines them with the privilege level and a virtualization flag. The verdict is one of three outcomes: allowed, an illegal-instruction exception, or a virtual-instruction exception.

Along with the verdict, the block returns the request address rounded down to the start of its cache block. Zeroing and management operations each have their own power-of-two block size. Translation, physical-memory protection and the memory accesses themselves belong to other units. This block only classifies the request and aligns its address.

A request is presented for one cycle with `req_valid`. The verdict and the aligned address are registered. They appear on the next cycle together with a one-cycle `rsp_done` pulse, and they hold until the next request.

Top module: `cbo_perm_check`

## Requirements
- R1: While `rst_n` is low at a clock edge, all outputs become 0 after that edge.
- R2: A request sampled with `req_valid` high produces its result and a single-cycle `rsp_done` pulse on the following cycle. Without a request, `rsp_done` stays low and the result outputs keep their last values, whatever the other inputs do.
- R3: On every `rsp_done`, exactly one of `rsp_allowed`, `rsp_illegal` and `rsp_virt_fault` is high.
- R4: Privilege code 3 (machine) is always allowed, regardless of the enable bits and `req_virt`. Privilege codes are U=0, S=1, M=3.
- R5: Below machine level, a cleared machine-layer enable bit for the operation gives an illegal-instruction result. This rule takes precedence over all other rules, including virtualization.
- R6: With `req_virt` high, privilege U or S, and the machine bit set, a cleared hypervisor-layer bit gives a virtual-instruction result.
- R7: With `req_virt` high, privilege U, and the machine and hypervisor bits set, a cleared supervisor-layer bit gives a virtual-instruction result.
- R8: With `req_virt` low, privilege U and the machine bit set, a cleared supervisor-layer bit gives an illegal-instruction result. With `req_virt` low, the hypervisor-layer bit has no effect and no virtual-instruction result is produced.
- R9: Operation codes are 0 zero, 1 clean, 2 flush and 3 invalidate. In each enable vector, bit 0 gates zero, bit 1 gates both clean and flush, and bit 2 gates invalidate. Bits belonging to other operations have no effect.
- R10: `rsp_addr` is `req_addr` with its low `ZERO_BLK_LOG2` bits cleared for zeroing, or its low `MGMT_BLK_LOG2` bits cleared for the other operations, whatever the verdict.
- R11: At privilege S, the supervisor-layer bit has no effect. For example, S with `req_virt` high, machine and hypervisor bits set and the supervisor bit cleared is allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_priv | input | 2 | Privilege level: U=0, S=1, M=3 |
| req_virt | input | 1 | Virtualization enabled |
| req_op | input | 2 | Operation: 0 zero, 1 clean, 2 flush, 3 invalidate |
| mcfg_en | input | 3 | Machine-layer enables: bit 0 zero, bit 1 clean/flush, bit 2 invalidate |
| hcfg_en | input | 3 | Hypervisor-layer enables, same layout |
| scfg_en | input | 3 | Supervisor-layer enables, same layout |
| req_addr | input | ADDR_W | Target address |
| rsp_done | output | 1 | One-cycle pulse marking a new result |
| rsp_allowed | output | 1 | Request may execute |
| rsp_illegal | output | 1 | Illegal-instruction exception |
| rsp_virt_fault | output | 1 | Virtual-instruction exception |
| rsp_addr | output | ADDR_W | Block-aligned address |

## Verification
A wrong internal state shows up at the ports one cycle after the request that exposes it. Examples are a misrouted enable bit, a priority step out of order, or a result register that loads without a request. Such a fault shows as a verdict or an aligned address on the following `rsp_done` that differs from the scoreboard entry. The bench sweeps every privilege, virtualization state and operation against all eight set/clear patterns of the three selected enable bits. The other operations' bits are driven opposite to the selected ones, so a wrong bit selection flips the verdict. A register that loads while idle, or a `rsp_done` that stretches past one cycle, is caught within a few idle cycles.

// File: rtl/cbo_perm_pkg.sv
// Shared encodings for the cache-block permission checker.
// Assumes privilege code 2 is never driven by the core.
package cbo_perm_pkg;
    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

    localparam int EN_W       = 3;
    localparam int EN_BIT_ZRO = 0;
    localparam int EN_BIT_CF  = 1;
    localparam int EN_BIT_INV = 2;

    typedef enum logic [1:0] {
        OP_ZERO  = 2'd0,
        OP_CLEAN = 2'd1,
        OP_FLUSH = 2'd2,
        OP_INVAL = 2'd3
    } cbo_op_e;

    typedef enum logic [1:0] {
        VERD_ALLOW   = 2'd0,
        VERD_ILLEGAL = 2'd1,
        VERD_VIRT    = 2'd2
    } verdict_e;

    // Position of the enable bit that gates a given operation
    function automatic int unsigned en_index(cbo_op_e op);
        case (op)
            OP_ZERO:  return EN_BIT_ZRO;
            OP_INVAL: return EN_BIT_INV;
            default:  return EN_BIT_CF;
        endcase
    endfunction
endpackage

// File: rtl/cbo_perm_decide.sv
// Combinational verdict for one request: picks the operation's bit
// from each enable layer and applies the fixed priority
// machine > virtual-instruction > supervisor illegal.
// Assumes the privilege code is one of U, S, M.
module cbo_perm_decide
    import cbo_perm_pkg::*;
(
    input  logic [1:0]      priv,
    input  logic            virt,
    input  cbo_op_e         op,
    input  logic [EN_W-1:0] m_en,
    input  logic [EN_W-1:0] h_en,
    input  logic [EN_W-1:0] s_en,
    output verdict_e        verdict
);
    logic m_bit, h_bit, s_bit;
    logic below_m, upto_s, below_s;

    // Select the gating bit of each layer for this operation
    always_comb begin
        m_bit = m_en[en_index(op)];
        h_bit = h_en[en_index(op)];
        s_bit = s_en[en_index(op)];
    end

    // Privilege comparisons used by the priority chain
    always_comb begin
        below_m = (priv < PRIV_M);
        upto_s  = (priv <= PRIV_S);
        below_s = (priv < PRIV_S);
    end

    // Priority chain, first matching rule wins
    always_comb begin
        if (below_m && !m_bit) begin
            verdict = VERD_ILLEGAL;
        end else if (virt && ((upto_s && !h_bit) || (below_s && !s_bit))) begin
            verdict = VERD_VIRT;
        end else if (below_s && !s_bit) begin
            verdict = VERD_ILLEGAL;
        end else begin
            verdict = VERD_ALLOW;
        end
    end
endmodule

// File: rtl/cbo_addr_align.sv
// Rounds an address down to a power-of-two block boundary.
// Assumes BLK_LOG2 is less than ADDR_W.
module cbo_addr_align #(
    parameter int ADDR_W   = 32,
    parameter int BLK_LOG2 = 6
) (
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);
    localparam logic [ADDR_W-1:0] LOW_MASK = (ADDR_W'(1) << BLK_LOG2) - ADDR_W'(1);

    // Clear the offset-within-block bits
    always_comb begin
        addr_out = addr_in & ~LOW_MASK;
    end
endmodule

// File: rtl/cbo_result_reg.sv
// Holds the verdict and aligned address of the last request and
// pulses done for one cycle after each request.
// Assumes one request per cycle at most.
module cbo_result_reg
    import cbo_perm_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  verdict_e          verdict,
    input  logic [ADDR_W-1:0] addr_in,
    output logic              done,
    output logic              allowed,
    output logic              illegal,
    output logic              virt_fault,
    output logic [ADDR_W-1:0] addr_q
);
    // Capture the result on a request, otherwise hold it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done       <= 1'b0;
            allowed    <= 1'b0;
            illegal    <= 1'b0;
            virt_fault <= 1'b0;
            addr_q     <= '0;
        end else begin
            done <= load;
            if (load) begin
                allowed    <= (verdict == VERD_ALLOW);
                illegal    <= (verdict == VERD_ILLEGAL);
                virt_fault <= (verdict == VERD_VIRT);
                addr_q     <= addr_in;
            end
        end
    end
endmodule

// File: rtl/cbo_perm_check.sv
// Top of the cache-block permission checker: classifies a zeroing or
// management request against three enable layers and returns a
// registered verdict and block-aligned address one cycle later.
// Assumes privilege code 2 is never presented.
module cbo_perm_check
    import cbo_perm_pkg::*;
#(
    parameter int ADDR_W        = 32,
    parameter int ZERO_BLK_LOG2 = 6,
    parameter int MGMT_BLK_LOG2 = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_priv,
    input  logic              req_virt,
    input  logic [1:0]        req_op,
    input  logic [2:0]        mcfg_en,
    input  logic [2:0]        hcfg_en,
    input  logic [2:0]        scfg_en,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_done,
    output logic              rsp_allowed,
    output logic              rsp_illegal,
    output logic              rsp_virt_fault,
    output logic [ADDR_W-1:0] rsp_addr
);
    cbo_op_e           op;
    verdict_e          verdict;
    logic [ADDR_W-1:0] zero_addr, mgmt_addr, sel_addr;
    logic              m_sel;

    // Interpret the raw operation code
    always_comb begin
        op = cbo_op_e'(req_op);
    end

    cbo_perm_decide u_decide (
        .priv    (req_priv),
        .virt    (req_virt),
        .op      (op),
        .m_en    (mcfg_en),
        .h_en    (hcfg_en),
        .s_en    (scfg_en),
        .verdict (verdict)
    );

    cbo_addr_align #(.ADDR_W(ADDR_W), .BLK_LOG2(ZERO_BLK_LOG2)) u_align_zero (
        .addr_in  (req_addr),
        .addr_out (zero_addr)
    );

    cbo_addr_align #(.ADDR_W(ADDR_W), .BLK_LOG2(MGMT_BLK_LOG2)) u_align_mgmt (
        .addr_in  (req_addr),
        .addr_out (mgmt_addr)
    );

    // Zeroing uses its own block size, all other operations share one
    always_comb begin
        sel_addr = (op == OP_ZERO) ? zero_addr : mgmt_addr;
    end

    cbo_result_reg #(.ADDR_W(ADDR_W)) u_result (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (req_valid),
        .verdict    (verdict),
        .addr_in    (sel_addr),
        .done       (rsp_done),
        .allowed    (rsp_allowed),
        .illegal    (rsp_illegal),
        .virt_fault (rsp_virt_fault),
        .addr_q     (rsp_addr)
    );

    // Machine-layer bit of the requested operation, for the checks below
    always_comb begin
        m_sel = mcfg_en[en_index(op)];
    end

    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> ($countones({rsp_allowed, rsp_illegal, rsp_virt_fault}) == 1)); // R3
    AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> $past(req_valid)); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_valid) |-> (!rsp_done && $stable(rsp_addr) && $stable(rsp_allowed))); // R2
    AST_MACHINE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_priv == PRIV_M) |=> rsp_allowed); // R4
    AST_MCFG_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_priv != PRIV_M && !m_sel) |=> rsp_illegal); // R5
    AST_NO_VIRT_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_virt) |=> !rsp_virt_fault); // R8
endmodule

// File: tb/tb_cbo_perm_check.sv
module tb_cbo_perm_check;
    localparam int AW = 32;
    localparam int ZL = 6;
    localparam int ML = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_priv = 2'd0;
    logic          req_virt = 1'b0;
    logic [1:0]    req_op = 2'd0;
    logic [2:0]    mcfg_en = 3'd0, hcfg_en = 3'd0, scfg_en = 3'd0;
    logic [AW-1:0] req_addr = '0;
    logic          rsp_done, rsp_allowed, rsp_illegal, rsp_virt_fault;
    logic [AW-1:0] rsp_addr;

    always #10 clk = ~clk;

    cbo_perm_check #(.ADDR_W(AW), .ZERO_BLK_LOG2(ZL), .MGMT_BLK_LOG2(ML)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_priv(req_priv),
        .req_virt(req_virt), .req_op(req_op), .mcfg_en(mcfg_en), .hcfg_en(hcfg_en),
        .scfg_en(scfg_en), .req_addr(req_addr), .rsp_done(rsp_done),
        .rsp_allowed(rsp_allowed), .rsp_illegal(rsp_illegal),
        .rsp_virt_fault(rsp_virt_fault), .rsp_addr(rsp_addr)
    );

    typedef struct {
        logic          a;
        logic          i;
        logic          v;
        logic [AW-1:0] addr;
        string         tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails  = 0;
    bit   finished = 0;
    exp_t last;

    // Expected result from the requirement rules
    function automatic exp_t model(input logic [1:0] p, input logic vt, input logic [1:0] op,
                                   input logic [2:0] m, input logic [2:0] h, input logic [2:0] s,
                                   input logic [AW-1:0] a);
        exp_t e;
        int   b;
        b = (op == 2'd0) ? 0 : (op == 2'd3) ? 2 : 1; // R9 bit layout
        e.a = 1'b0; e.i = 1'b0; e.v = 1'b0;
        if (p == 2'd3) begin
            e.a = 1'b1; e.tag = "R4";
        end else if (!m[b]) begin
            e.i = 1'b1; e.tag = "R5";
        end else if (vt && !h[b]) begin
            e.v = 1'b1; e.tag = "R6";
        end else if (vt && p == 2'd0 && !s[b]) begin
            e.v = 1'b1; e.tag = "R7";
        end else if (p == 2'd0 && !s[b]) begin
            e.i = 1'b1; e.tag = "R8";
        end else begin
            e.a = 1'b1;
            e.tag = (p == 2'd1 && !s[b]) ? "R11" : "R9";
        end
        if (op == 2'd0) e.addr = a & ~((AW'(1) << ZL) - AW'(1));
        else            e.addr = a & ~((AW'(1) << ML) - AW'(1));
        return e;
    endfunction

    // Driver: present one request for one cycle and record its expectation
    task automatic send(input logic [1:0] p, input logic vt, input logic [1:0] op,
                        input logic [2:0] m, input logic [2:0] h, input logic [2:0] s,
                        input logic [AW-1:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_priv = p; req_virt = vt; req_op = op;
        mcfg_en = m; hcfg_en = h; scfg_en = s; req_addr = a;
        last = model(p, vt, op, m, h, s, a);
        q.push_back(last);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compare each result against the scoreboard
    always @(negedge clk) begin
        if (rst_n && !finished && rsp_done) begin
            if (q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R2: done with no pending request, actual done=1 expected done=0");
            end else begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (rsp_allowed !== e.a || rsp_illegal !== e.i || rsp_virt_fault !== e.v ||
                    rsp_addr !== e.addr) begin
                    fails++;
                    $display("FAIL %s/R10: actual a=%b i=%b v=%b addr=%h expected a=%b i=%b v=%b addr=%h",
                             e.tag, rsp_allowed, rsp_illegal, rsp_virt_fault, rsp_addr,
                             e.a, e.i, e.v, e.addr);
                end
                checks++;
                if ($countones({rsp_allowed, rsp_illegal, rsp_virt_fault}) != 1) begin
                    fails++;
                    $display("FAIL R3: actual flags=%b expected one-hot",
                             {rsp_allowed, rsp_illegal, rsp_virt_fault});
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            fails++;
            $display("FAIL watchdog: actual run still busy expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [1:0] plist [3];
        plist[0] = 2'd0; plist[1] = 2'd1; plist[2] = 2'd3;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if ({rsp_done, rsp_allowed, rsp_illegal, rsp_virt_fault} !== 4'b0 || rsp_addr !== '0) begin
            fails++;
            $display("FAIL R1: actual flags=%b addr=%h expected all zero",
                     {rsp_done, rsp_allowed, rsp_illegal, rsp_virt_fault}, rsp_addr);
        end

        // Directed cases
        send(2'd3, 1'b1, 2'd3, 3'b000, 3'b000, 3'b000, 32'hDEAD_BEEF); // R4
        send(2'd1, 1'b1, 2'd1, 3'b000, 3'b000, 3'b000, 32'h0000_00FF); // R5 over virt
        send(2'd1, 1'b1, 2'd2, 3'b111, 3'b000, 3'b111, 32'h1234_5678); // R6
        send(2'd0, 1'b1, 2'd0, 3'b111, 3'b111, 3'b000, 32'hFFFF_FFFF); // R7
        send(2'd0, 1'b0, 2'd3, 3'b111, 3'b111, 3'b000, 32'h8000_007F); // R8
        send(2'd1, 1'b0, 2'd1, 3'b111, 3'b000, 3'b000, 32'h0000_0040); // R8 hyp bit ignored
        send(2'd1, 1'b1, 2'd3, 3'b111, 3'b111, 3'b000, 32'h0000_0080); // R11
        send(2'd0, 1'b0, 2'd3, 3'b011, 3'b111, 3'b111, 32'hABCD_0101); // R9 inval bit cleared
        send(2'd0, 1'b0, 2'd0, 3'b001, 3'b000, 3'b001, 32'h0000_003F); // R10 zero block
        idle(3);

        // R2: inputs change without a request, outputs must hold
        @(negedge clk);
        req_priv = 2'd0; req_virt = 1'b1; req_op = 2'd1;
        mcfg_en = 3'b000; hcfg_en = 3'b000; scfg_en = 3'b000; req_addr = 32'h5555_5555;
        repeat (3) @(negedge clk);
        checks++;
        if (rsp_done !== 1'b0 || rsp_allowed !== last.a || rsp_illegal !== last.i ||
            rsp_virt_fault !== last.v || rsp_addr !== last.addr) begin
            fails++;
            $display("FAIL R2: actual d=%b a=%b i=%b v=%b addr=%h expected d=0 a=%b i=%b v=%b addr=%h",
                     rsp_done, rsp_allowed, rsp_illegal, rsp_virt_fault, rsp_addr,
                     last.a, last.i, last.v, last.addr);
        end

        // Sweep: selected bits per pattern, other operations' bits opposite (R9)
        for (int pi = 0; pi < 3; pi++) begin
            for (int vt = 0; vt < 2; vt++) begin
                for (int op = 0; op < 4; op++) begin
                    for (int c = 0; c < 8; c++) begin
                        logic [2:0] one, m, h, s;
                        int b;
                        b = (op == 0) ? 0 : (op == 3) ? 2 : 1;
                        one = 3'(1 << b);
                        m = c[2] ? one : (~one & 3'b111);
                        h = c[1] ? one : (~one & 3'b111);
                        s = c[0] ? one : (~one & 3'b111);
                        send(plist[pi], vt[0], op[1:0], m, h, s,
                             32'h1234_5678 + AW'(c) * 32'h0101_0137 + AW'(op) * 32'h0000_0F11);
                    end
                end
            end
        end
        idle(4);

        // R2: every request answered exactly once
        checks++;
        if (q.size() != 0) begin
            fails++;
            $display("FAIL R2: actual pending=%0d expected pending=0", q.size());
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule